// File: doc/BRIEF.md
# Recursive Low-Pass Filter Operation Sequencer

This block is the control core of a third-order recursive low-pass filter. The filter borrows one floating-point multiplier and one floating-point adder that live outside the block. A slow sample tick, in the tens of kilohertz, starts each computation. On a tick the block takes a 16-bit signed sample and converts it exactly to IEEE single precision. It then runs a fixed script of seven multiplies and six adds through the two external units, one request at a time. When the script ends, it presents the new output with a one-cycle valid pulse.

The block keeps the filter's history in registers: the three previous inputs and the three previous outputs. The coefficients are constants set by parameter. The output is y = b0·x0 + b1·x1 + b2·x2 + b3·x3 − a1·y1 − a2·y2 − a3·y3. Each subtraction is done by inverting the sign bit of the product before it goes to the adder, so the adder only ever adds.

A tick that arrives while a computation is running is dropped, and it sets a sticky overrun flag. With four-cycle arithmetic units at 50 MHz, one output takes a little over fifty cycles. That is far inside the period of a roughly 43 kHz tick.

Top module: `iir_sequencer`

## Requirements
- R1: While reset is held and after it is released, mul_req, add_req, y_valid and overrun are 0. y_out is 0x00000000 and every history register reads zero, so the first output after reset uses zero for x1..x3 and y1..y3.
- R2: When tick is high and the block is idle, sample_in is converted exactly to IEEE-754 single precision: bit 31 is the sign, bits 30:23 hold the exponent biased by 127, and bits 22:0 hold the fraction. Zero maps to 0x00000000, 1 maps to 0x3F800000 and −32768 maps to 0xC7000000. The converted value is the multiplicand of the first multiply.
- R3: Each accepted tick produces exactly seven mul_req pulses and six add_req pulses, followed by exactly one y_valid pulse. No request is raised while y_valid is high.
- R4: A request is a one-cycle pulse. At most one request, to either unit, is outstanding at a time. The operands of a unit stay unchanged from its request until its done.
- R5: The multiplies run in a fixed order. Multiply k (k = 0..6) presents coefficient k from the list b0, b1, b2, b3, a1, a2, a3 on mul_a. On mul_b it presents the matching value from the list x0, x1, x2, x3, y1, y2, y3.
- R6: The first product starts the running sum. Add j (j = 0..5) presents the running sum on add_a and the product of multiply j+1 on add_b. For the three a-terms (multiplies 4..6), bit 31 of that product is inverted. The sum from add_done becomes the new running sum.
- R7: After each output, the history shifts: x2 moves to x3, x1 to x2, x0 to x1, y2 to y3, y1 to y2, and the new output becomes y1. The next tick's output therefore depends on the earlier samples and outputs.
- R8: y_valid is high for exactly one cycle per output. y_out carries the final sum in that cycle and keeps that value until the next y_valid.
- R9: A tick that arrives while a computation is in progress (any cycle that is not idle) sets overrun. overrun stays set until reset. Such a tick starts nothing and does not change the history.
- R10: A mul_done or add_done that arrives while that unit has no outstanding request is ignored. It does not change the output, the history or the order of operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample strobe, one cycle per new sample |
| sample_in | input | 16 | Signed input sample, read when tick is high |
| mul_req | output | 1 | One-cycle request to the multiplier |
| mul_a | output | 32 | Multiplier operand: coefficient |
| mul_b | output | 32 | Multiplier operand: input or output history value |
| mul_done | input | 1 | Multiplier result valid |
| mul_res | input | 32 | Multiplier result |
| add_req | output | 1 | One-cycle request to the adder |
| add_a | output | 32 | Adder operand: running sum |
| add_b | output | 32 | Adder operand: product, sign-inverted for a-terms |
| add_done | input | 1 | Adder result valid |
| add_res | input | 32 | Adder result |
| y_out | output | 32 | Latest filter output |
| y_valid | output | 1 | One-cycle pulse marking a new output |
| overrun | output | 1 | Sticky flag: a tick arrived while busy |

## Verification
Single samples at the extremes (0, ±1, −32768, 32767) test the exact integer-to-float conversion and the sign handling, because each converted value is compared bit for bit. A stream of mixed-sign samples with distinct, non-symmetric coefficients tests the operation order and the history shift: swapping any two taps, dropping the sign flip on an a-term, or shifting the history wrongly gives a different output. The units' response latency is changed between one and four cycles to show that the sequencing depends only on the done signals. Ticks that arrive mid-computation and done pulses with no request outstanding are then checked to leave both the result and the following outputs unchanged.

// File: rtl/iir_seq_pkg.sv
package iir_seq_pkg;

    localparam int FP_W   = 32;
    localparam int SMP_W  = 16;
    localparam int MAN_W  = 23;
    localparam int EXP_BIAS = 127;

    typedef logic [FP_W-1:0] fp32_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL_ISSUE,
        ST_MUL_WAIT,
        ST_ADD_ISSUE,
        ST_ADD_WAIT,
        ST_EMIT
    } seq_state_e;

    // Exact signed integer to single precision (valid for SMP_W <= 23)
    function automatic fp32_t int_to_fp(input logic signed [SMP_W-1:0] s);
        logic [SMP_W:0]       mag;
        logic [SMP_W+MAN_W:0] wide;
        logic [7:0]           lead;
        fp32_t                r;
        mag  = s[SMP_W-1] ? (~{s[SMP_W-1], s} + 1'b1) : {1'b0, s};
        lead = '0;
        for (int i = 0; i <= SMP_W; i++) begin
            if (mag[i]) lead = 8'(i);
        end
        wide = (SMP_W+MAN_W+1)'(mag) << (MAN_W - int'(lead));
        if (mag == '0) r = '0;
        else r = {s[SMP_W-1], 8'(EXP_BIAS) + lead, wide[MAN_W-1:0]};
        return r;
    endfunction

    function automatic fp32_t fp_negate(input fp32_t v);
        return {~v[FP_W-1], v[FP_W-2:0]};
    endfunction

endpackage

// File: rtl/iir_history.sv
module iir_history
    import iir_seq_pkg::*;
#(
    parameter int ORDER = 3,
    localparam int NOPS = 2*ORDER + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_x,
    input  logic signed [SMP_W-1:0] sample,
    input  logic                    shift,
    input  fp32_t                   y_new,
    output fp32_t                   ops [NOPS]
);

    fp32_t xs [ORDER+1];
    fp32_t ys [ORDER+1];   // ys[0] unused

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k <= ORDER; k++) begin
                xs[k] <= '0;
                ys[k] <= '0;
            end
        end else begin
            if (load_x) xs[0] <= int_to_fp(sample);
            if (shift) begin
                for (int k = 1; k <= ORDER; k++) xs[k] <= xs[k-1];
                ys[1] <= y_new;
                for (int k = 2; k <= ORDER; k++) ys[k] <= ys[k-1];
            end
        end
    end

    for (genvar k = 0; k <= ORDER; k++) begin : g_xop
        assign ops[k] = xs[k];
    end
    for (genvar k = 1; k <= ORDER; k++) begin : g_yop
        assign ops[ORDER+k] = ys[k];
    end

endmodule

// File: rtl/iir_op_mux.sv
module iir_op_mux
    import iir_seq_pkg::*;
#(
    parameter int ORDER = 3,
    localparam int NOPS = 2*ORDER + 1,
    localparam int STEP_W = $clog2(NOPS),
    parameter logic [FP_W*NOPS-1:0] COEFS = '0
) (
    input  logic [STEP_W-1:0] step,
    input  fp32_t             ops [NOPS],
    output fp32_t             coef,
    output fp32_t             operand,
    output logic              feedback
);

    fp32_t ctab [NOPS];

    for (genvar k = 0; k < NOPS; k++) begin : g_coef
        assign ctab[k] = COEFS[FP_W*(NOPS-1-k) +: FP_W];
    end

    assign coef     = ctab[step];
    assign operand  = ops[step];
    assign feedback = (int'(step) > ORDER);

endmodule

// File: rtl/iir_seq_fsm.sv
module iir_seq_fsm
    import iir_seq_pkg::*;
#(
    parameter int ORDER = 3,
    localparam int NOPS = 2*ORDER + 1,
    localparam int STEP_W = $clog2(NOPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              feedback,
    input  logic              mul_done,
    input  fp32_t             mul_res,
    input  logic              add_done,
    input  fp32_t             add_res,
    output logic [STEP_W-1:0] step,
    output logic              mul_req,
    output logic              add_req,
    output fp32_t             acc,
    output fp32_t             prod,
    output logic              load_x,
    output logic              emit,
    output logic              overrun
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(NOPS-1);

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            step    <= '0;
            acc     <= '0;
            prod    <= '0;
            overrun <= 1'b0;
        end else begin
            if (tick && state != ST_IDLE) overrun <= 1'b1;
            unique case (state)
                ST_IDLE: if (tick) begin
                    step  <= '0;
                    state <= ST_MUL_ISSUE;
                end
                ST_MUL_ISSUE: state <= ST_MUL_WAIT;
                ST_MUL_WAIT: if (mul_done) begin
                    if (step == '0) begin
                        acc   <= mul_res;
                        step  <= step + 1'b1;
                        state <= ST_MUL_ISSUE;
                    end else begin
                        prod  <= feedback ? fp_negate(mul_res) : mul_res;
                        state <= ST_ADD_ISSUE;
                    end
                end
                ST_ADD_ISSUE: state <= ST_ADD_WAIT;
                ST_ADD_WAIT: if (add_done) begin
                    acc <= add_res;
                    if (step == LAST) begin
                        state <= ST_EMIT;
                    end else begin
                        step  <= step + 1'b1;
                        state <= ST_MUL_ISSUE;
                    end
                end
                ST_EMIT: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mul_req = (state == ST_MUL_ISSUE);
    assign add_req = (state == ST_ADD_ISSUE);
    assign load_x  = (state == ST_IDLE) && tick;
    assign emit    = (state == ST_EMIT);

endmodule

// File: rtl/iir_sequencer.sv
module iir_sequencer
    import iir_seq_pkg::*;
#(
    parameter int ORDER = 3,
    localparam int NOPS = 2*ORDER + 1,
    localparam int STEP_W = $clog2(NOPS),
    // b0, b1, b2, b3, a1, a2, a3 from most to least significant word
    parameter logic [FP_W*NOPS-1:0] COEFS = {
        32'h3E000000, 32'h3EC00000, 32'h3EC00000, 32'h3E000000,
        32'hBF000000, 32'h3E800000, 32'hBE000000
    }
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic signed [SMP_W-1:0] sample_in,
    output logic                    mul_req,
    output logic [FP_W-1:0]         mul_a,
    output logic [FP_W-1:0]         mul_b,
    input  logic                    mul_done,
    input  logic [FP_W-1:0]         mul_res,
    output logic                    add_req,
    output logic [FP_W-1:0]         add_a,
    output logic [FP_W-1:0]         add_b,
    input  logic                    add_done,
    input  logic [FP_W-1:0]         add_res,
    output logic [FP_W-1:0]         y_out,
    output logic                    y_valid,
    output logic                    overrun
);

    fp32_t             ops [NOPS];
    fp32_t             acc, prod, coef, operand;
    logic [STEP_W-1:0] step;
    logic              feedback, load_x, emit;

    iir_seq_fsm #(.ORDER(ORDER)) u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .feedback(feedback),
        .mul_done(mul_done), .mul_res(mul_res),
        .add_done(add_done), .add_res(add_res),
        .step(step), .mul_req(mul_req), .add_req(add_req),
        .acc(acc), .prod(prod), .load_x(load_x), .emit(emit),
        .overrun(overrun)
    );

    iir_history #(.ORDER(ORDER)) u_hist (
        .clk(clk), .rst(rst), .load_x(load_x), .sample(sample_in),
        .shift(emit), .y_new(acc), .ops(ops)
    );

    iir_op_mux #(.ORDER(ORDER), .COEFS(COEFS)) u_mux (
        .step(step), .ops(ops), .coef(coef), .operand(operand),
        .feedback(feedback)
    );

    assign mul_a   = coef;
    assign mul_b   = operand;
    assign add_a   = acc;
    assign add_b   = prod;
    assign y_valid = emit;
    // newest output: the final sum while emitting, the y1 history word after
    assign y_out   = emit ? acc : ops[ORDER+1];

endmodule

// File: rtl/iir_sequencer_chk.sv
module iir_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        mul_req,
    input logic [31:0] mul_a,
    input logic [31:0] mul_b,
    input logic        mul_done,
    input logic        add_req,
    input logic [31:0] add_a,
    input logic [31:0] add_b,
    input logic        add_done,
    input logic [31:0] y_out,
    input logic        y_valid,
    input logic        overrun
);

    logic mul_pend, add_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            mul_pend <= 1'b0;
            add_pend <= 1'b0;
        end else begin
            if (mul_req) mul_pend <= 1'b1;
            else if (mul_done) mul_pend <= 1'b0;
            if (add_req) add_pend <= 1'b1;
            else if (add_done) add_pend <= 1'b0;
        end
    end

    // R4
    a_r4_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        (mul_req || add_req) |-> (!mul_pend && !add_pend && !(mul_req && add_req)));
    a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
        (mul_req || add_req) |=> (!mul_req && !add_req));
    a_r4_mul_operands_held: assert property (@(posedge clk) disable iff (rst)
        mul_pend |-> ($stable(mul_a) && $stable(mul_b)));
    a_r4_add_operands_held: assert property (@(posedge clk) disable iff (rst)
        add_pend |-> ($stable(add_a) && $stable(add_b)));
    // R3
    a_r3_valid_quiet: assert property (@(posedge clk) disable iff (rst)
        y_valid |-> (!mul_req && !add_req && !mul_pend && !add_pend));
    // R8
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        y_valid |=> !y_valid);
    a_r8_output_held: assert property (@(posedge clk) disable iff (rst)
        !y_valid |-> $stable(y_out));
    // R9
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
    a_r9_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (tick && (mul_pend || add_pend)) |=> overrun);

endmodule

bind iir_sequencer iir_sequencer_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick),
    .mul_req(mul_req), .mul_a(mul_a), .mul_b(mul_b), .mul_done(mul_done),
    .add_req(add_req), .add_a(add_a), .add_b(add_b), .add_done(add_done),
    .y_out(y_out), .y_valid(y_valid), .overrun(overrun)
);

// File: tb/iir_sequencer_test.sv
module iir_sequencer_test;

    localparam logic [31:0] CF [7] = '{
        32'h3FC00000, 32'hC0000000, 32'h3F400000, 32'h40400000,
        32'h3F000000, 32'hBFA00000, 32'h3F200000
    };
    localparam logic [223:0] CF_VEC = {
        32'h3FC00000, 32'hC0000000, 32'h3F400000, 32'h40400000,
        32'h3F000000, 32'hBFA00000, 32'h3F200000
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               tick = 1'b0;
    logic signed [15:0] sample_in = '0;
    logic               mul_req, add_req, y_valid, overrun;
    logic [31:0]        mul_a, mul_b, add_a, add_b, y_out;
    logic               mul_done = 1'b0, add_done = 1'b0;
    logic [31:0]        mul_res = '0, add_res = '0;

    int checks = 0;
    int failures = 0;
    int lat = 1;
    int vcount = 0;

    logic [31:0] m_a [16];
    logic [31:0] m_b [16];
    logic [31:0] m_r [16];
    logic [31:0] a_a [16];
    logic [31:0] a_b [16];
    int mcnt = 0, acnt = 0;

    logic [31:0] rx [4];
    logic [31:0] ry [4];

    always #10 clk = ~clk;

    iir_sequencer #(.COEFS(CF_VEC)) uut (
        .clk(clk), .rst(rst), .tick(tick), .sample_in(sample_in),
        .mul_req(mul_req), .mul_a(mul_a), .mul_b(mul_b),
        .mul_done(mul_done), .mul_res(mul_res),
        .add_req(add_req), .add_a(add_a), .add_b(add_b),
        .add_done(add_done), .add_res(add_res),
        .y_out(y_out), .y_valid(y_valid), .overrun(overrun)
    );

    function automatic real f2r(input logic [31:0] f);
        logic [63:0] d;
        if (f[30:0] == '0) return 0.0;
        d = {f[31], 11'(f[30:23]) - 11'd127 + 11'd1023, f[22:0], 29'd0};
        return $bitstoreal(d);
    endfunction

    function automatic logic [31:0] r2f(input real r);
        logic [63:0] d;
        logic [10:0] e;
        d = $realtobits(r);
        if (d[62:0] == '0) return 32'h0;
        e = d[62:52];
        return {d[63], 8'(e - 11'd1023 + 11'd127), d[51:29]};
    endfunction

    function automatic logic [31:0] fmul(input logic [31:0] a, input logic [31:0] b);
        return r2f(f2r(a) * f2r(b));
    endfunction

    function automatic logic [31:0] fadd(input logic [31:0] a, input logic [31:0] b);
        return r2f(f2r(a) + f2r(b));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // multiplier model
    initial begin
        forever begin
            @(negedge clk);
            while (mul_req) begin
                if (mcnt < 16) begin m_a[mcnt] = mul_a; m_b[mcnt] = mul_b; end
                repeat (lat) @(negedge clk);
                mul_res = fmul(m_a[mcnt < 16 ? mcnt : 15], m_b[mcnt < 16 ? mcnt : 15]);
                if (mcnt < 16) m_r[mcnt] = mul_res;
                mcnt++;
                mul_done = 1'b1;
                @(negedge clk);
                mul_done = 1'b0;
            end
        end
    end

    // adder model
    initial begin
        forever begin
            @(negedge clk);
            while (add_req) begin
                if (acnt < 16) begin a_a[acnt] = add_a; a_b[acnt] = add_b; end
                repeat (lat) @(negedge clk);
                add_res = fadd(a_a[acnt < 16 ? acnt : 15], a_b[acnt < 16 ? acnt : 15]);
                acnt++;
                add_done = 1'b1;
                @(negedge clk);
                add_done = 1'b0;
            end
        end
    end

    always @(negedge clk) if (y_valid) vcount++;

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin rx[k] = '0; ry[k] = '0; end
    endtask

    // run one sample; optional second tick mid-computation
    task automatic run_sample(input logic signed [15:0] s, input bit extra_tick,
                              input logic signed [15:0] s2);
        logic [31:0] opl [7];
        logic [31:0] p [7];
        logic [31:0] acc;
        int waited;
        int v0;
        rx[0] = r2f(real'(s));
        opl = '{rx[0], rx[1], rx[2], rx[3], ry[1], ry[2], ry[3]};
        for (int k = 0; k < 7; k++) p[k] = fmul(CF[k], opl[k]);
        acc = p[0];
        for (int k = 1; k < 7; k++) acc = fadd(acc, (k >= 4) ? {~p[k][31], p[k][30:0]} : p[k]);
        mcnt = 0; acnt = 0; v0 = vcount;
        @(negedge clk);
        tick = 1'b1; sample_in = s;
        @(negedge clk);
        tick = 1'b0; sample_in = '0;
        if (extra_tick) begin
            repeat (4) @(negedge clk);
            tick = 1'b1; sample_in = s2;
            @(negedge clk);
            tick = 1'b0; sample_in = '0;
        end
        waited = 0;
        while (!y_valid && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check("R3 valid pulse seen", 32'(y_valid), 32'd1);
        check("R8 y_out at valid", y_out, acc);
        check("R3 multiply count", 32'(mcnt), 32'd7);
        check("R3 add count", 32'(acnt), 32'd6);
        check("R2 converted sample", m_b[0], rx[0]);
        for (int k = 0; k < 7; k++) begin
            check("R5 coefficient order", m_a[k], CF[k]);
            check("R5 operand order", m_b[k], opl[k]);
        end
        check("R6 seed sum", a_a[0], m_r[0]);
        for (int j = 0; j < 6; j++)
            check("R6 add operand sign", a_b[j],
                  (j + 1 >= 4) ? {~m_r[j+1][31], m_r[j+1][30:0]} : m_r[j+1]);
        @(negedge clk);
        check("R8 valid one cycle", 32'(y_valid), 32'd0);
        check("R8 y_out held", y_out, acc);
        repeat (20) @(negedge clk);
        check("R9 one output per accepted tick", 32'(vcount - v0), 32'd1);
        check("R8 y_out still held", y_out, acc);
        // history update, R7
        rx[3] = rx[2]; rx[2] = rx[1]; rx[1] = rx[0];
        ry[3] = ry[2]; ry[2] = ry[1]; ry[1] = acc;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 mul_req", 32'(mul_req), 32'd0);
        check("R1 add_req", 32'(add_req), 32'd0);
        check("R1 y_valid", 32'(y_valid), 32'd0);
        check("R1 overrun", 32'(overrun), 32'd0);
        check("R1 y_out", y_out, 32'h0);
    endtask

    task automatic t_convert();
        lat = 1;
        run_sample(16'sd0, 1'b0, 16'sd0);
        check("R2 zero", m_b[0], 32'h00000000);
        run_sample(16'sd1, 1'b0, 16'sd0);
        check("R2 one", m_b[0], 32'h3F800000);
        run_sample(-16'sd32768, 1'b0, 16'sd0);
        check("R2 most negative", m_b[0], 32'hC7000000);
        run_sample(16'sd32767, 1'b0, 16'sd0);
        check("R2 most positive", m_b[0], 32'h46FFFE00);
        run_sample(-16'sd1, 1'b0, 16'sd0);
        check("R2 minus one", m_b[0], 32'hBF800000);
    endtask

    task automatic t_stream();
        lat = 4;
        run_sample(16'sd1000, 1'b0, 16'sd0);
        run_sample(-16'sd2000, 1'b0, 16'sd0);
        run_sample(16'sd12345, 1'b0, 16'sd0);
        run_sample(-16'sd7, 1'b0, 16'sd0);
        check("R7 history after stream", m_b[1], r2f(12345.0));
    endtask

    task automatic t_overrun();
        lat = 2;
        check("R9 clear before", 32'(overrun), 32'd0);
        run_sample(16'sd300, 1'b1, 16'sd9999);
        check("R9 overrun set", 32'(overrun), 32'd1);
        run_sample(-16'sd450, 1'b0, 16'sd0);
        check("R9 overrun sticky", 32'(overrun), 32'd1);
    endtask

    task automatic t_stray_done();
        logic [31:0] held;
        lat = 3;
        held = y_out;
        @(negedge clk);
        mul_done = 1'b1; mul_res = 32'h40A00000;
        add_done = 1'b1; add_res = 32'hC1200000;
        @(negedge clk);
        mul_done = 1'b0; add_done = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 no output from stray done", 32'(y_valid), 32'd0);
        check("R10 y_out unchanged", y_out, held);
        run_sample(16'sd77, 1'b0, 16'sd0);
    endtask

    task automatic t_reset_clears();
        do_reset();
        @(negedge clk);
        check("R1 overrun cleared", 32'(overrun), 32'd0);
        check("R1 y_out cleared", y_out, 32'h0);
        lat = 1;
        run_sample(16'sd5, 1'b0, 16'sd0);
        check("R1 history zero after reset", m_b[1], 32'h0);
    endtask

    initial begin
        t_reset();
        t_convert();
        t_stream();
        t_overrun();
        t_stray_done();
        t_reset_clears();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule